// File: doc/BRIEF.md
# Run-Control Sequencer with Entry and Exit Pulses

This block is a two-state controller that follows a level-sensitive request input. While the request is low, the controller waits. When the request goes high, the controller enters its active phase. It leaves the active phase and returns to waiting when the request drops. Downstream logic gets two kinds of indication. The first is a single-cycle pulse on entry to the active phase and another on exit from it. The second is a level that is high for the whole active phase.

Every output is taken directly from a flip-flop, with no logic after it. The state register and all three output registers are loaded from the next-state value. This way the level output and the pulses change on the same clock edge. The design uses no edge detector and no extra intermediate state.

Top module: `run_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state is waiting and `begin_pulse`, `end_pulse` and `active` are all low. A high `req` during reset has no effect.
- R2: In the waiting state, a high `req` sampled at a clock edge moves the state to active. On that same edge `begin_pulse` rises, and it stays high for exactly one cycle.
- R3: In the active state, a low `req` sampled at a clock edge moves the state back to waiting. On that same edge `end_pulse` rises, and it stays high for exactly one cycle.
- R4: `active` is high in every cycle the state is active and low in every cycle it is waiting. It rises on the same edge as `begin_pulse` and falls on the same edge as `end_pulse`.
- R5: While `req` stays high in the active state, no further `begin_pulse` occurs. While `req` stays low in the waiting state, no `end_pulse` occurs.
- R6: `begin_pulse` and `end_pulse` are never high in the same cycle.
- R7: If `req` toggles on every cycle, `begin_pulse` and `end_pulse` alternate on consecutive cycles, and `active` follows the state with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Level-sensitive run request |
| begin_pulse | output | 1 | One-cycle pulse on entry to the active state |
| end_pulse | output | 1 | One-cycle pulse on exit from the active state |
| active | output | 1 | High while in the active state |

## Verification
All three outputs respond exactly one clock edge after `req` is sampled. A value placed on `req` before edge N shows on the outputs just after edge N. The bench model advances its own state at each rising edge and computes the expected outputs from it. The bench then compares every output on the following falling edge, so each comparison falls in the cycle the result is due. The stimulus covers four patterns: `req` held high during reset, long holds at each level, single-cycle requests, and toggling on every cycle.

// File: rtl/run_seq.sv
module run_seq (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic begin_pulse,
  output logic end_pulse,
  output logic active
);
  typedef enum logic {ST_WAIT = 1'b0, ST_RUN = 1'b1} st_t;

  st_t st_q, st_d;
  logic go_in, go_out;

  always_comb begin
    st_d   = st_q;
    go_in  = 1'b0;
    go_out = 1'b0;
    case (st_q)
      ST_WAIT: if (req)  begin st_d = ST_RUN;  go_in  = 1'b1; end
      ST_RUN:  if (!req) begin st_d = ST_WAIT; go_out = 1'b1; end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_WAIT;
      begin_pulse <= 1'b0;
      end_pulse   <= 1'b0;
      active      <= 1'b0;
    end else begin
      st_q        <= st_d;
      begin_pulse <= go_in;
      end_pulse   <= go_out;
      active      <= (st_d == ST_RUN);
    end
  end
endmodule

// File: rtl/run_seq_chk.sv
module run_seq_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic begin_pulse,
  input logic end_pulse,
  input logic active
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!active && !begin_pulse && !end_pulse));

  // R2
  start_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !active && req) |=> (begin_pulse && active));

  // R3
  stop_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && active && !req) |=> (end_pulse && !active));

  // R4
  level_align_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> ($rose(active) == begin_pulse) && ($fell(active) == end_pulse));

  // R5
  no_extra_start_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && active && req) |=> !begin_pulse);

  // R6
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({begin_pulse, end_pulse}));
endmodule

bind run_seq run_seq_chk chk_i (
  .clk(clk), .rst(rst), .req(req),
  .begin_pulse(begin_pulse), .end_pulse(end_pulse), .active(active)
);

// File: tb/run_seq_tb_top.sv
`timescale 1ns/1ps
module run_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic begin_pulse, end_pulse, active;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit m_run = 0, m_b = 0, m_e = 0;
  bit done = 0;

  always #4 clk = ~clk;

  run_seq dut_i (.clk(clk), .rst(rst), .req(req),
                 .begin_pulse(begin_pulse), .end_pulse(end_pulse), .active(active));

  // reference model: decides from the previous model state at each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_run <= 0; m_b <= 0; m_e <= 0;
    end else begin
      m_b   <= (!m_run && req);
      m_e   <= (m_run && !req);
      m_run <= req;
    end
  end

  function automatic string tag_of(bit b, bit e, bit a);
    if (rst) return "R1";
    if (b) return "R2";
    if (e) return "R3";
    return a ? "R5" : "R4";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (begin_pulse !== m_b || end_pulse !== m_e || active !== m_run) begin
        failures++;
        $display("FAIL %s cyc=%0d actual b/e/a=%b%b%b expected=%b%b%b",
                 tag_of(m_b, m_e, m_run), cyc, begin_pulse, end_pulse, active, m_b, m_e, m_run);
      end
      checks++;
      if (begin_pulse && end_pulse) begin
        failures++;
        $display("FAIL R6 cyc=%0d actual both=1 expected onehot0", cyc);
      end
    end
  end

  task automatic drive(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); req = v;
    end
  endtask

  int pulses;
  initial begin
    req = 1'b1;                 // R1: request held high during reset
    repeat (4) @(negedge clk);
    rst = 1'b0; req = 1'b0;
    drive(0, 5);
    drive(1, 10);               // R2, R5
    drive(0, 10);               // R3, R5
    drive(1, 1); drive(0, 3);   // single-cycle request
    pulses = 0;
    for (int i = 0; i < 20; i++) begin   // R7 toggling
      @(negedge clk); req = ~req;
      if (i > 1) begin
        checks++;
        if ((begin_pulse ^ end_pulse) !== 1'b1) begin
          failures++;
          $display("FAIL R7 i=%0d actual b/e=%b%b expected one of them", i, begin_pulse, end_pulse);
        end
      end
    end
    drive(1, 2);
    @(negedge clk); rst = 1'b1; req = 1'b1;
    @(negedge clk); @(negedge clk);
    checks++;
    if (active !== 0 || begin_pulse !== 0 || end_pulse !== 0) begin
      failures++;
      $display("FAIL R1 actual b/e/a=%b%b%b expected 000", begin_pulse, end_pulse, active);
    end
    rst = 1'b0;
    drive(1, 4);
    drive(0, 4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule